// File: doc/BRIEF.md
# Set/Reset Compare PWM Timer Channel

This block is one timer channel with a free-running 16-bit up counter and two compare registers, called A and B. When pulse-width output is enabled, a compare match on A sets the output pin high and a compare match on B drives it low. Between those events the pin keeps its last value. The period comes from the counter-clear select: the counter goes back to zero on the tick after it matches the chosen register. The duty cycle comes from where A and B sit inside that period.

A two-bit combination-mode input is shared with neighbouring channels and has higher priority than the enable. When it names one of the paired-channel waveform modes, this channel's set/reset output is turned off no matter what the enable says. The compare-match flags work in every mode. Each flag stays set until a clear strobe arrives for it.

Top module: `pwm_sr_channel`

## Requirements
- R1: While rst_n is low at a clock edge, the counter, pwm_out, match_flag_a and match_flag_b all go to 0.
- R2: On each edge with tick_en high the counter adds 1 and wraps from 16'hFFFF to 0. With tick_en low it holds its value.
- R3: clr_sel 2'b01 selects register A and 2'b10 selects register B. 2'b00 and 2'b11 select no clear. On an edge with tick_en high where the counter equals the selected register, the counter becomes 0 in place of the increment.
- R4: The output is active when pwm_en is 1 and combo_mode[1] is 0. While it is active, an edge with tick_en high and counter equal to cmp_a sets pwm_out to 1.
- R5: While the output is active, an edge with tick_en high and counter equal to cmp_b sets pwm_out to 0. If A and B match on the same edge, pwm_out goes to 0.
- R6: While the output is active and no compare match happens on an edge, pwm_out keeps its value.
- R7: With pwm_en at 0, pwm_out is driven to 0 on every edge.
- R8: combo_mode 2'b10 or 2'b11 overrides pwm_en = 1 and drives pwm_out to 0 on every edge. Values 2'b00 and 2'b01 leave pwm_en in control.
- R9: An edge with tick_en high and counter equal to cmp_a sets match_flag_a. The same holds for cmp_b and match_flag_b. This happens in every mode, and a set flag stays set.
- R10: A high flag_clr_a or flag_clr_b clears its flag on that edge. A match on the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count enable; also qualifies compare matches |
| cmp_a | input | 16 | Compare register A (set edge) |
| cmp_b | input | 16 | Compare register B (reset edge) |
| pwm_en | input | 1 | Set/reset PWM enable, 0 = normal operation |
| combo_mode | input | 2 | Combination-mode field; bit 1 set overrides pwm_en |
| clr_sel | input | 2 | Counter clear source: 01 = A, 10 = B, else none |
| flag_clr_a | input | 1 | Clear strobe for match_flag_a |
| flag_clr_b | input | 1 | Clear strobe for match_flag_b |
| count | output | 16 | Current counter value |
| pwm_out | output | 1 | PWM output pin |
| match_flag_a | output | 1 | Sticky compare-match flag for A |
| match_flag_b | output | 1 | Sticky compare-match flag for B |

## Verification
Two situations are hard to reach from the ports. One is a match on A and a match on B in the same tick. The other is the counter wrap, because with a clear selected the counter never gets near 16'hFFFF. The random phase keeps both compare values in a small range and clears often, so coincident matches and clear/match interplay come up many times. A directed step sets A equal to B to force the tie. A second directed run with no clear source ticks the counter through a full wrap while the output is enabled.

// File: rtl/pwm_sr_pkg.sv
// Package: shared encodings for the set/reset PWM channel.
// Assumes two-bit select fields, decoded the same way by every user.
package pwm_sr_pkg;
    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_A    = 2'b01,
        CLR_B    = 2'b10,
        CLR_RSVD = 2'b11
    } clr_src_e;

    // Bit 1 set marks a paired-channel mode that owns the output.
    function automatic logic combo_owns_output(input logic [1:0] mode);
        return mode[1];
    endfunction
endpackage

// File: rtl/sr_counter.sv
// Module: up counter with a synchronous clear on a selected compare match.
// Assumes clr_hit is already qualified by tick, so a clear wins over the increment.
module sr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr_hit,
    output logic [W-1:0] cnt
);
    // Count on ticks, clear to zero on a selected match.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (clr_hit) cnt <= '0;
        else if (tick)    cnt <= cnt + 1'b1;
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr_hit) |=> cnt == $past(cnt) + 1'b1);
    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr_hit) |=> $stable(cnt));
    // R3
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> cnt == '0);
endmodule

// File: rtl/sr_compare.sv
// Module: bank of N equality comparators against the running count.
// Assumes a match counts only on a tick, so a paused counter does not retrigger.
module sr_compare #(
    parameter int W = 16,
    parameter int N = 2
) (
    input  logic                tick,
    input  logic [W-1:0]        cnt,
    input  logic [N-1:0][W-1:0] cmp_vals,
    output logic [N-1:0]        hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        // Qualified equality for register i.
        always_comb hit[i] = tick && (cnt == cmp_vals[i]);
    end
endmodule

// File: rtl/sr_flag.sv
// Module: sticky event flag with a clear strobe; a set wins over a clear.
// Assumes set and clr are single-cycle qualified events.
module sr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Latch events until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    // R10
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);
    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/sr_output.sv
// Module: set/reset output register; the reset event has priority.
// Assumes active already includes the combination-mode override.
module sr_output (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic set_hit,
    input  logic rst_hit,
    output logic pin
);
    // Drive the pin from the compare events, or low when inactive.
    always_ff @(posedge clk) begin
        if (!rst_n)       pin <= 1'b0;
        else if (!active) pin <= 1'b0;
        else if (rst_hit) pin <= 1'b0;
        else if (set_hit) pin <= 1'b1;
    end

    // R4
    out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && set_hit && !rst_hit) |=> pin);
    // R5
    out_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rst_hit) |=> !pin);
    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !set_hit && !rst_hit) |=> $stable(pin));
    // R7
    out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !pin);
endmodule

// File: rtl/pwm_sr_channel.sv
// Module: timer channel that produces a set/reset PWM from two compare registers.
// Assumes all inputs are synchronous to clk; the combination-mode field outranks pwm_en.
module pwm_sr_channel
    import pwm_sr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic             pwm_en,
    input  logic [1:0]       combo_mode,
    input  logic [1:0]       clr_sel,
    input  logic             flag_clr_a,
    input  logic             flag_clr_b,
    output logic [CNT_W-1:0] count,
    output logic             pwm_out,
    output logic             match_flag_a,
    output logic             match_flag_b
);
    localparam int NCMP = 2;
    localparam int IDX_A = 0;
    localparam int IDX_B = 1;

    logic [NCMP-1:0][CNT_W-1:0] cmp_vals;
    logic [NCMP-1:0]            hit;
    logic [NCMP-1:0]            fclr;
    logic [NCMP-1:0]            flags;
    logic                       clr_hit;
    logic                       out_active;
    clr_src_e                   clr_src;

    // Pack the compare registers and clear strobes for the banks.
    always_comb begin
        cmp_vals[IDX_A] = cmp_a;
        cmp_vals[IDX_B] = cmp_b;
        fclr[IDX_A]     = flag_clr_a;
        fclr[IDX_B]     = flag_clr_b;
    end

    // Pick the counter clear event from the selected register.
    always_comb begin
        clr_src = clr_src_e'(clr_sel);
        unique case (clr_src)
            CLR_A:   clr_hit = hit[IDX_A];
            CLR_B:   clr_hit = hit[IDX_B];
            default: clr_hit = 1'b0;
        endcase
    end

    // The output is ours only when enabled and not claimed by a combination mode.
    always_comb out_active = pwm_en && !combo_owns_output(combo_mode);

    sr_counter #(.W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .clr_hit(clr_hit), .cnt(count)
    );

    sr_compare #(.W(CNT_W), .N(NCMP)) cmp_i (
        .tick(tick_en), .cnt(count), .cmp_vals(cmp_vals), .hit(hit)
    );

    for (genvar i = 0; i < NCMP; i++) begin : g_flag
        sr_flag flag_i (
            .clk(clk), .rst_n(rst_n), .set(hit[i]), .clr(fclr[i]), .flag(flags[i])
        );
    end

    sr_output out_i (
        .clk(clk), .rst_n(rst_n), .active(out_active),
        .set_hit(hit[IDX_A]), .rst_hit(hit[IDX_B]), .pin(pwm_out)
    );

    assign match_flag_a = flags[IDX_A];
    assign match_flag_b = flags[IDX_B];

    // R8
    combo_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        combo_mode[1] |=> !pwm_out);
    // R3
    clr_a_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && clr_sel == 2'b01 && count == cmp_a) |=> count == '0);
    // R3
    clr_b_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && clr_sel == 2'b10 && count == cmp_b) |=> count == '0);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !pwm_out && !match_flag_a && !match_flag_b));
endmodule

// File: tb/pwm_sr_channel_tb_top.sv
`timescale 1ns/1ps
module pwm_sr_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en;
    logic [15:0] cmp_a, cmp_b;
    logic        pwm_en;
    logic [1:0]  combo_mode, clr_sel;
    logic        flag_clr_a, flag_clr_b;
    logic [15:0] count;
    logic        pwm_out, match_flag_a, match_flag_b;

    int errors = 0;
    int checks = 0;

    // Reference state, kept independently of the design.
    logic [15:0] m_cnt;
    logic        m_out, m_fa, m_fb;

    always #2.5 clk = ~clk;

    pwm_sr_channel dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .pwm_en(pwm_en), .combo_mode(combo_mode), .clr_sel(clr_sel),
        .flag_clr_a(flag_clr_a), .flag_clr_b(flag_clr_b), .count(count),
        .pwm_out(pwm_out), .match_flag_a(match_flag_a), .match_flag_b(match_flag_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] next_cnt(input logic [15:0] c, input logic hc, input logic t);
        return hc ? 16'd0 : (t ? c + 16'd1 : c);
    endfunction

    function automatic logic next_out(input logic act, input logic ma, input logic mb, input logic o);
        return !act ? 1'b0 : (mb ? 1'b0 : (ma ? 1'b1 : o));
    endfunction

    // One clock: predict from the current inputs, then compare at the falling edge.
    task automatic cycle();
        logic ma, mb, act, hc;
        logic [15:0] e_cnt;
        logic e_out, e_fa, e_fb;
        string ctag, otag;
        ma  = tick_en && (m_cnt == cmp_a);
        mb  = tick_en && (m_cnt == cmp_b);
        act = pwm_en && !combo_mode[1];
        hc  = (clr_sel == 2'b01 && ma) || (clr_sel == 2'b10 && mb);
        if (!rst_n) begin
            e_cnt = 0; e_out = 0; e_fa = 0; e_fb = 0;
            ctag = "R1"; otag = "R1";
        end else begin
            e_cnt = next_cnt(m_cnt, hc, tick_en);
            e_out = next_out(act, ma, mb, m_out);
            e_fa  = ma ? 1'b1 : (flag_clr_a ? 1'b0 : m_fa);
            e_fb  = mb ? 1'b1 : (flag_clr_b ? 1'b0 : m_fb);
            ctag  = hc ? "R3" : "R2";
            if (combo_mode[1])  otag = "R8";
            else if (!pwm_en)   otag = "R7";
            else if (mb)        otag = "R5";
            else if (ma)        otag = "R4";
            else                otag = "R6";
        end
        @(posedge clk);
        @(negedge clk);
        chk({ctag, " count"}, 32'(count), 32'(e_cnt));
        chk({otag, " pwm_out"}, 32'(pwm_out), 32'(e_out));
        chk((flag_clr_a && !ma) ? "R10 flag_a" : "R9 flag_a", 32'(match_flag_a), 32'(e_fa));
        chk((flag_clr_b && !mb) ? "R10 flag_b" : "R9 flag_b", 32'(match_flag_b), 32'(e_fb));
        m_cnt = e_cnt; m_out = e_out; m_fa = e_fa; m_fb = e_fb;
    endtask

    task automatic idle_inputs();
        tick_en = 0; pwm_en = 0; combo_mode = 0; clr_sel = 0;
        flag_clr_a = 0; flag_clr_b = 0; cmp_a = 0; cmp_b = 0;
    endtask

    task automatic random_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en    = ($urandom % 4) != 0;
            pwm_en     = ($urandom % 5) != 0;
            combo_mode = (($urandom % 6) == 0) ? 2'(2 + $urandom % 2) : 2'($urandom % 2);
            clr_sel    = 2'($urandom % 4);
            flag_clr_a = ($urandom % 10) == 0;
            flag_clr_b = ($urandom % 10) == 0;
            if (($urandom % 16) == 0) cmp_a = 16'($urandom % 20);
            if (($urandom % 16) == 0) cmp_b = 16'($urandom % 20);
            cycle();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs();
        rst_n = 0;
        m_cnt = 16'hx; m_out = 1'bx; m_fa = 1'bx; m_fb = 1'bx;
        cycle();
        cycle();
        rst_n = 1;
        // R1: idle after reset with no ticks
        cycle();

        // R4 then R5: set at 3, reset at 7, period via clear on B
        cmp_a = 3; cmp_b = 7; clr_sel = 2'b10; pwm_en = 1; tick_en = 1;
        for (int i = 0; i < 20; i++) cycle();

        // R5: A equal to B forces a tie, output must go low
        cmp_a = 5; cmp_b = 5; clr_sel = 2'b01;
        for (int i = 0; i < 14; i++) cycle();

        // R8: override with pwm_en still 1
        cmp_a = 2; cmp_b = 9; clr_sel = 2'b10; combo_mode = 2'b11;
        for (int i = 0; i < 12; i++) cycle();
        combo_mode = 2'b10;
        for (int i = 0; i < 12; i++) cycle();
        combo_mode = 2'b01;
        for (int i = 0; i < 12; i++) cycle();

        // R10: clear strobe together with a match, then alone
        flag_clr_a = 1; flag_clr_b = 1;
        for (int i = 0; i < 12; i++) cycle();
        flag_clr_a = 0; flag_clr_b = 0;

        random_cycles(3000);

        // R1: reset in the middle of activity
        rst_n = 0; cycle(); rst_n = 1;

        // R2: full wrap with no clear source, output enabled
        combo_mode = 0; pwm_en = 1; tick_en = 1; clr_sel = 2'b11;
        cmp_a = 16'hFFFE; cmp_b = 16'h0001; flag_clr_a = 0; flag_clr_b = 0;
        for (int i = 0; i < 65540; i++) cycle();

        random_cycles(1000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #900000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule